// File: doc/BRIEF.md
# Serial-in latched parallel-out converter

This block converts a serial bit stream into a 16-bit parallel word. Each rising edge of the shift clock moves one serial bit into an internal shift register. A word-wide hold stage sits between that register and the parallel output pins. Two active-low controls govern the hold stage: a strobe and a clear.

While the strobe is high, the outputs stay frozen. A host can therefore shift a complete new word without disturbing the downstream logic. Pulling the strobe low makes the hold stage follow the shift register. The word appears at once, and any further shifting ripples through to the outputs. Releasing the strobe freezes whatever value was last shown.

The active-low clear empties only the hold stage, so the outputs read zero whatever the strobe does. The shift register keeps its contents and keeps shifting while the clear is asserted. A synchronous active-high reset zeroes both storage stages.

The hold stage is built from flops on the shift clock, not from a true latch. The combinational output path selects between three sources: zero, the live shift register, or the held word. That path gives the transparent behaviour.

Top module: `s2p_converter`

## Requirements
- R1: After reset, the shift register and the hold stage are all zeros, so the parallel output reads 0 whether the strobe is high or low.
- R2: On each rising edge of the shift clock, the serial input enters bit 0 and every stored bit moves one place toward bit 15. After 16 edges, the first bit sent sits in bit 15.
- R3: While the strobe is high and the clear is high, the parallel output does not change, whatever the shift clock and serial input do.
- R4: While the strobe is low and the clear is high, the parallel output equals the current shift register contents, including after each further shift edge.
- R5: When the strobe returns high, the parallel output keeps the last word it showed while the strobe was low.
- R6: While the clear is low, the parallel output is 0 regardless of the strobe, the serial input and the shift clock.
- R7: The clear never changes the shift register. Bits shifted in while the clear is low appear on the output once the clear is high and the strobe is low.
- R8: A clear held low across a shift clock edge empties the hold stage. If the clear then rises while the strobe is high, the output reads 0 until the strobe goes low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shift clock; shifting happens on the rising edge |
| rst | input | 1 | Synchronous active-high reset of both storage stages |
| ser_in | input | 1 | Serial data bit |
| strobe_n | input | 1 | Active-low strobe: low makes the hold stage transparent |
| clear_n | input | 1 | Active-low clear of the hold stage and outputs |
| par_out | output | 16 | Parallel output word |

## Verification
On every shift edge, the assertions check that the bit-0 entry and the upward move of stored bits are correct. They check that a cleared output is zero, that a transparent output matches the shift register, and that the output stays frozen across consecutive strobe-high cycles.

Three behaviours are spread over many cycles, and only the bench scenarios can show them. The first is that a word shifted in during a clear survives and appears once the clear lifts. The second is that a clear leaves an empty held word behind once it is released. The third is that the last transparent word is kept when the strobe rises.

// File: rtl/s2p_pkg.sv
package s2p_pkg;

    localparam int unsigned S2P_WIDTH = 16;

    typedef enum logic [1:0] {
        VIEW_CLEARED = 2'd0,
        VIEW_LIVE    = 2'd1,
        VIEW_HELD    = 2'd2
    } view_e;

    typedef struct packed {
        logic serial;
        logic strobe_n;
        logic clear_n;
    } ctl_t;

    function automatic view_e pick_view(input ctl_t c);
        if (!c.clear_n)
            return VIEW_CLEARED;
        else if (!c.strobe_n)
            return VIEW_LIVE;
        else
            return VIEW_HELD;
    endfunction

    function automatic logic hold_loads(input ctl_t c);
        return c.clear_n && !c.strobe_n;
    endfunction

endpackage

// File: rtl/s2p_shift.sv
module s2p_shift #(
    parameter int unsigned WIDTH = s2p_pkg::S2P_WIDTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_in,
    output logic [WIDTH-1:0] word_q,
    output logic [WIDTH-1:0] word_next
);
    localparam int unsigned TOP = WIDTH - 1;

    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        if (i == 0) begin : g_entry
            assign word_next[i] = bit_in;
        end else begin : g_move
            assign word_next[i] = word_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            word_q <= '0;
        else
            word_q <= word_next;
    end

    // R2: new bit lands in bit 0, older bits move up by one
    assert_shift_order_R2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (word_q == {$past(word_q[TOP-1:0]), $past(bit_in)}));

endmodule

// File: rtl/s2p_hold.sv
module s2p_hold #(
    parameter int unsigned WIDTH = s2p_pkg::S2P_WIDTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             zero,
    input  logic [WIDTH-1:0] word_d,
    output logic [WIDTH-1:0] held_q
);
    always_ff @(posedge clk) begin
        if (rst || zero)
            held_q <= '0;
        else if (load)
            held_q <= word_d;
    end

    // R8: a clear seen at an edge leaves the held word empty
    assert_hold_empty_R8: assert property (@(posedge clk) disable iff (rst)
        zero |=> (held_q == '0));

    // R4: a transparent edge captures the word being shown next
    assert_hold_track_R4: assert property (@(posedge clk) disable iff (rst)
        (load && !zero) |=> (held_q == $past(word_d)));

endmodule

// File: rtl/s2p_outmux.sv
module s2p_outmux #(
    parameter int unsigned WIDTH = s2p_pkg::S2P_WIDTH
) (
    input  s2p_pkg::view_e   view,
    input  logic [WIDTH-1:0] live,
    input  logic [WIDTH-1:0] held,
    output logic [WIDTH-1:0] word_out
);
    import s2p_pkg::*;

    always_comb begin
        unique case (view)
            VIEW_LIVE: word_out = live;
            VIEW_HELD: word_out = held;
            default:   word_out = '0;
        endcase
    end

endmodule

// File: rtl/s2p_converter.sv
module s2p_converter #(
    parameter int unsigned WIDTH = s2p_pkg::S2P_WIDTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ser_in,
    input  logic             strobe_n,
    input  logic             clear_n,
    output logic [WIDTH-1:0] par_out
);
    import s2p_pkg::*;

    ctl_t             ctl;
    view_e            view;
    logic [WIDTH-1:0] shift_q;
    logic [WIDTH-1:0] shift_d;
    logic [WIDTH-1:0] held_q;

    assign ctl  = '{serial: ser_in, strobe_n: strobe_n, clear_n: clear_n};
    assign view = pick_view(ctl);

    s2p_shift #(.WIDTH(WIDTH)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .bit_in    (ctl.serial),
        .word_q    (shift_q),
        .word_next (shift_d)
    );

    s2p_hold #(.WIDTH(WIDTH)) u_hold (
        .clk    (clk),
        .rst    (rst),
        .load   (hold_loads(ctl)),
        .zero   (!ctl.clear_n),
        .word_d (shift_d),
        .held_q (held_q)
    );

    s2p_outmux #(.WIDTH(WIDTH)) u_mux (
        .view     (view),
        .live     (shift_q),
        .held     (held_q),
        .word_out (par_out)
    );

    // R6: clear forces a zero output
    assert_clear_zero_R6: assert property (@(posedge clk) disable iff (rst)
        !clear_n |-> (par_out == '0));

    // R4: transparent output equals the shift register
    assert_transparent_R4: assert property (@(posedge clk) disable iff (rst)
        (clear_n && !strobe_n) |-> (par_out == shift_q));

    // R3: output frozen across consecutive strobe-high cycles
    assert_frozen_R3: assert property (@(posedge clk) disable iff (rst)
        (clear_n && strobe_n) ##1 (clear_n && strobe_n) |-> $stable(par_out));

endmodule

// File: tb/s2p_converter_test.sv
module s2p_converter_test;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         ser_in = 1'b0;
    logic         strobe_n = 1'b1;
    logic         clear_n = 1'b1;
    logic [W-1:0] par_out;

    int n_cmp = 0;
    int n_bad = 0;
    logic [W-1:0] m_sh = '0;
    logic [W-1:0] m_hold = '0;

    always #10 clk = ~clk;

    s2p_converter uut (
        .clk(clk), .rst(rst), .ser_in(ser_in),
        .strobe_n(strobe_n), .clear_n(clear_n), .par_out(par_out)
    );

    function automatic logic [W-1:0] expect_out(logic [W-1:0] sh, logic [W-1:0] hd,
                                                logic s, logic c);
        if (!c) return '0;
        if (!s) return sh;
        return hd;
    endfunction

    function automatic string mode_tag(logic s, logic c);
        if (!c) return "R6";
        if (!s) return "R4";
        return "R3";
    endfunction

    task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_edge();
        if (rst) begin
            m_sh = '0;
            m_hold = '0;
        end else begin
            m_sh = {m_sh[W-2:0], ser_in};
            if (!clear_n) m_hold = '0;
            else if (!strobe_n) m_hold = m_sh;
        end
    endtask

    task automatic tick(logic d, logic s, logic c);
        @(negedge clk);
        ser_in = d; strobe_n = s; clear_n = c;
        #1 check(mode_tag(s, c), par_out, expect_out(m_sh, m_hold, s, c));
        @(posedge clk);
        model_edge();
        #1 check(mode_tag(s, c), par_out, expect_out(m_sh, m_hold, s, c));
    endtask

    task automatic send_word(logic [W-1:0] w, logic s, logic c);
        for (int i = W - 1; i >= 0; i--) tick(w[i], s, c);
    endtask

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [W-1:0] seen;
        void'($urandom(32'd1234));
        repeat (2) begin
            @(posedge clk);
            model_edge();
        end
        @(negedge clk);
        rst = 1'b0;
        #1 check("R1", par_out, '0);
        strobe_n = 1'b0;
        #1 check("R1", par_out, '0);
        strobe_n = 1'b1;

        // R2: ordering after 16 edges
        send_word(16'hA5C3, 1'b1, 1'b1);
        @(negedge clk);
        strobe_n = 1'b0;
        #1 check("R2", par_out, 16'hA5C3);
        @(posedge clk);
        model_edge();

        // R4: follow further edges while transparent
        tick(1'b1, 1'b0, 1'b1);
        tick(1'b0, 1'b0, 1'b1);
        tick(1'b1, 1'b0, 1'b1);

        // R5: strobe rise keeps last word
        @(negedge clk);
        seen = par_out;
        strobe_n = 1'b1;
        #1 check("R5", par_out, seen);
        @(posedge clk);
        model_edge();
        #1 check("R5", par_out, seen);
        send_word(16'h0FF0, 1'b1, 1'b1);
        check("R3", par_out, seen);

        // R6/R7/R8: shift under clear
        send_word(16'h3C96, 1'b1, 1'b0);
        @(negedge clk);
        clear_n = 1'b1;
        #1 check("R8", par_out, '0);
        strobe_n = 1'b0;
        #1 check("R7", par_out, 16'h3C96);
        strobe_n = 1'b1;
        #1 check("R8", par_out, '0);
        @(posedge clk);
        model_edge();
        tick(1'b1, 1'b0, 1'b0);
        check("R6", par_out, '0);

        // constrained random mix
        for (int k = 0; k < 600; k++) begin
            logic d, s, c;
            d = 1'($urandom);
            s = ($urandom_range(0, 3) == 0);
            c = ($urandom_range(0, 7) != 0);
            tick(d, s, c);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule